// File: doc/BRIEF.md
# Secure Configuration Register Bank

This block is the register bank of a memory protection filter. It lives in a 4 KB window, decodes word-aligned offsets and accepts byte, halfword and word accesses that each carry a secure/non-secure attribute. It holds the control bits, an index into a per-block security table, the table words, the interrupt enable and status, two fault-information words and a set of read-only identification bytes. The filter datapath reads the table and the control bits from this block. When the filter blocks an access, it sends a one-cycle fault strobe back with the fault details.

Software reaches the table indirectly. It loads the index register and then reads or writes the table data register. With auto-increment enabled, each word access moves the index to the next table word, so the whole table can be streamed. A sticky lockdown bit freezes the security-relevant registers until reset. Non-secure requesters see only the identification bytes. Every access completes in the cycle it is presented. Read data is combinational, and writes take effect at the clock edge that ends the access.

Top module: `sec_cfg_regbank`

## Requirements
- R1: After reset, the control word reads 0x00000100, the index reads 0, the interrupt enable reads 1, and the status, both fault words and every table word read 0.
- R2: The control word (offset 0x00) keeps only bit 4 (error response for blocked accesses), bit 8 (index auto-increment) and bit 31 (lockdown). All other bits read 0 and ignore writes. The three kept bits appear on `ctl_err_resp`, `ctl_autoinc` and `ctl_lockdown`.
- R3: A non-secure access (`req_secure`=0) to any offset below 0xFD0 reads 0 and changes no state. Non-secure reads of offsets 0xFD0 to 0xFFC return the identification bytes.
- R4: While lockdown is set, writes to control (0x00), table data (0x1C) and interrupt enable (0x28) are ignored, and a blocked table write does not advance the index. Index writes (0x18) still work. Only reset clears lockdown.
- R5: A write to the index (0x18) stores the value modulo the number of table words. Offset 0x10 reads the number of table words minus one. Offset 0x14 reads log2(block size) minus 5.
- R6: A word access to table data (0x1C) reads or writes the table word selected by the index. If auto-increment is set, the index then advances by one and wraps to 0 after the last word. Byte and halfword accesses never advance it, and nothing advances it while auto-increment is clear.
- R7: A byte or halfword write to control, index or table data replaces only the addressed lanes of the current value. A sub-word write to any other register is zero-extended to a full word first. Write data is given right-aligned in `req_wdata`. `req_size` is 0 for byte, 1 for halfword and 2 for word.
- R8: A sub-word read returns the addressed lanes of the register, shifted down by 8×`req_addr[1:0]`, with the upper bits zero.
- R9: Writing 1 to bit 0 of 0x34 sets the interrupt status. Writing 1 to bit 0 of 0x24 clears it, and a write with bit 0 = 0 has no effect. Status reads at 0x20 and enable at 0x28 (bit 0). `irq` is high exactly when status and enable are both 1.
- R10: A fault strobe while status is 0 sets status. It loads fault word 1 (0x2C) with the fault address and fault word 2 (0x30) with bits [15:0] = requester id, bit 16 = non-secure flag and bit 17 = table configuration bit. A strobe while status is 1 captures nothing. A strobe in the same cycle as a clear write leaves status set.
- R11: Offsets 0xFD0 to 0xFFC read, in address order, the bytes 04 00 00 00 60 B8 1B 00 0D F0 05 B1, and writes to them are ignored. Reads of 0x24, 0x34 and undefined offsets return 0.
- R12: `lut_words` bits [32k+31:32k] always hold table word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_secure | input | 1 | Secure attribute of the access |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Right-aligned write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| fault_strobe | input | 1 | One-cycle blocked-access event from the filter |
| fault_addr | input | 32 | Address of the blocked access |
| fault_master | input | 16 | Requester id of the blocked access |
| fault_nonsec | input | 1 | Blocked access was non-secure |
| fault_cfg_ns | input | 1 | Table bit that applied to the blocked access |
| irq | output | 1 | Interrupt request |
| ctl_err_resp | output | 1 | Error-response control bit |
| ctl_autoinc | output | 1 | Auto-increment control bit |
| ctl_lockdown | output | 1 | Lockdown control bit |
| lut_words | output | TBL_WORDS*32 | Flattened table contents |

## Verification
The assertions assume that at most one register access occurs per cycle. They also assume that `fault_strobe` pulses are independent of bus accesses and that the address bits above the window are already stripped. The stimulus follows these assumptions. It drives a single access or an idle cycle on each clock and raises the strobe for one edge at a time. It overlaps the strobe with a clear write exactly once, on purpose, to exercise the stated priority. Byte and halfword accesses use only lane offsets that keep the access inside the word.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

  localparam int CTRL_ERR_BIT  = 4;
  localparam int CTRL_INC_BIT  = 8;
  localparam int CTRL_LOCK_BIT = 31;

  // word offsets (byte offset >> 2)
  localparam logic [9:0] W_CTRL   = 10'h000;
  localparam logic [9:0] W_MAXIDX = 10'h004;
  localparam logic [9:0] W_BLKCFG = 10'h005;
  localparam logic [9:0] W_INDEX  = 10'h006;
  localparam logic [9:0] W_TABLE  = 10'h007;
  localparam logic [9:0] W_STAT   = 10'h008;
  localparam logic [9:0] W_CLR    = 10'h009;
  localparam logic [9:0] W_EN     = 10'h00A;
  localparam logic [9:0] W_INFO1  = 10'h00B;
  localparam logic [9:0] W_INFO2  = 10'h00C;
  localparam logic [9:0] W_SET    = 10'h00D;
  localparam logic [9:0] W_IDBASE = 10'h3F4;

  typedef struct packed {
    logic ctrl;
    logic maxidx;
    logic blkcfg;
    logic index;
    logic table_d;
    logic stat;
    logic clr;
    logic en;
    logic info1;
    logic info2;
    logic set;
    logic ident;
  } reg_sel_t;

  function automatic logic [31:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // deposit right-aligned data into the addressed lanes of old
  function automatic logic [31:0] merge_word(logic [31:0] old, logic [31:0] data,
                                             logic [1:0] sz, logic [1:0] lane);
    logic [4:0]  sh;
    logic [31:0] m;
    sh = {lane, 3'b000};
    m  = size_mask(sz) << sh;
    return (old & ~m) | ((data << sh) & m);
  endfunction

  // pull the addressed lanes down to bit 0
  function automatic logic [31:0] extract_lanes(logic [31:0] w, logic [1:0] sz,
                                                logic [1:0] lane);
    logic [4:0] sh;
    sh = {lane, 3'b000};
    return (w >> sh) & size_mask(sz);
  endfunction

  function automatic logic [7:0] id_byte(logic [9:0] woff);
    case (woff)
      10'h3F4: return 8'h04;
      10'h3F5: return 8'h00;
      10'h3F6: return 8'h00;
      10'h3F7: return 8'h00;
      10'h3F8: return 8'h60;
      10'h3F9: return 8'hB8;
      10'h3FA: return 8'h1B;
      10'h3FB: return 8'h00;
      10'h3FC: return 8'h0D;
      10'h3FD: return 8'hF0;
      10'h3FE: return 8'h05;
      10'h3FF: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  // {lock, autoinc, err} out of a control word image
  function automatic logic [2:0] ctrl_bits(logic [31:0] w);
    return {w[CTRL_LOCK_BIT], w[CTRL_INC_BIT], w[CTRL_ERR_BIT]};
  endfunction

endpackage

// File: rtl/scr_bus_decode.sv
module scr_bus_decode
  import sec_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_secure,
  input  logic [9:0] word_off,
  output logic       wr_go,
  output logic       rd_go,
  output reg_sel_t   sel
);

  logic in_id_space;
  logic visible;

  assign in_id_space = (word_off >= W_IDBASE);
  assign visible     = req_secure | in_id_space;
  assign wr_go       = req_valid & visible & req_write;
  assign rd_go       = req_valid & visible & ~req_write;

  always_comb begin
    sel        = '0;
    sel.ident  = in_id_space;
    case (word_off)
      W_CTRL:   sel.ctrl    = 1'b1;
      W_MAXIDX: sel.maxidx  = 1'b1;
      W_BLKCFG: sel.blkcfg  = 1'b1;
      W_INDEX:  sel.index   = 1'b1;
      W_TABLE:  sel.table_d = 1'b1;
      W_STAT:   sel.stat    = 1'b1;
      W_CLR:    sel.clr     = 1'b1;
      W_EN:     sel.en      = 1'b1;
      W_INFO1:  sel.info1   = 1'b1;
      W_INFO2:  sel.info2   = 1'b1;
      W_SET:    sel.set     = 1'b1;
      default:  ;
    endcase
  end

  a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R3: a non-secure request below the ID space never reaches a register
  a_r3_ns_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_secure && word_off < W_IDBASE) |-> !(wr_go || rd_go));

endmodule

// File: rtl/scr_table.sv
module scr_table #(
  parameter int TBL_WORDS = 7,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   idx_wr,
  input  logic [31:0]            idx_wdata,
  input  logic                   tbl_wr,
  input  logic [31:0]            tbl_wdata,
  input  logic                   step,
  output logic [IDX_W-1:0]       idx,
  output logic [31:0]            cur_word,
  output logic [TBL_WORDS*32-1:0] lut_flat
);

  logic [31:0] words [TBL_WORDS];

  function automatic logic [IDX_W-1:0] fold_index(logic [31:0] v);
    logic [31:0] r;
    r = v % 32'(TBL_WORDS);
    return r[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] next_index(logic [IDX_W-1:0] cur);
    if (32'(cur) == TBL_WORDS - 1) return '0;
    return cur + 1'b1;
  endfunction

  for (genvar k = 0; k < TBL_WORDS; k++) begin : g_word
    logic [31:0] q;
    logic        hit;
    assign hit = tbl_wr && (32'(idx) == k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= tbl_wdata;
    end
    assign words[k]           = q;
    assign lut_flat[k*32 +: 32] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_wr) idx <= fold_index(idx_wdata);
    else if (step)   idx <= next_index(idx);
  end

  assign cur_word = words[idx];

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx) < TBL_WORDS);

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_wr && 32'(idx) == TBL_WORDS - 1) |=> (idx == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !idx_wr) |=> $stable(idx));

endmodule

// File: rtl/scr_irq_ctrl.sv
module scr_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        en_bit,
  input  logic        set_hit,
  input  logic        clr_hit,
  input  logic        fault_strobe,
  input  logic [31:0] fault_addr,
  input  logic [15:0] fault_master,
  input  logic        fault_nonsec,
  input  logic        fault_cfg_ns,
  output logic        status,
  output logic        enable,
  output logic [31:0] info1,
  output logic [31:0] info2,
  output logic        irq
);

  logic fault_take;

  assign fault_take = fault_strobe & ~status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      enable <= 1'b1;
      info1  <= '0;
      info2  <= '0;
    end else begin
      status <= set_hit | fault_strobe | (status & ~clr_hit);
      if (en_wr) enable <= en_bit;
      if (fault_take) begin
        info1 <= fault_addr;
        info2 <= {14'd0, fault_cfg_ns, fault_nonsec, fault_master};
      end
    end
  end

  assign irq = status & enable;

  a_r10_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_strobe && !status) |=> status);

  a_r10_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    status |=> ($stable(info1) && $stable(info2)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_hit && !fault_strobe) |=> !status);

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> status);

endmodule

// File: rtl/sec_cfg_regbank.sv
module sec_cfg_regbank
  import sec_cfg_pkg::*;
#(
  parameter int NUM_BLOCKS = 200,
  parameter int BLK_LOG2   = 12,
  localparam int TBL_WORDS = (NUM_BLOCKS + 31) / 32,
  localparam int IDX_W     = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_secure,
  input  logic [11:0]             req_addr,
  input  logic [1:0]              req_size,
  input  logic [31:0]             req_wdata,
  output logic [31:0]             rdata,
  input  logic                    fault_strobe,
  input  logic [31:0]             fault_addr,
  input  logic [15:0]             fault_master,
  input  logic                    fault_nonsec,
  input  logic                    fault_cfg_ns,
  output logic                    irq,
  output logic                    ctl_err_resp,
  output logic                    ctl_autoinc,
  output logic                    ctl_lockdown,
  output logic [TBL_WORDS*32-1:0] lut_words
);

  localparam logic [31:0] MAXIDX_VAL = 32'(TBL_WORDS - 1);
  localparam logic [31:0] BLKCFG_VAL = 32'(BLK_LOG2 - 5);

  logic [9:0]       word_off;
  logic [1:0]       lane;
  logic             wr_go, rd_go;
  reg_sel_t         sel;
  logic             word_acc;

  logic [31:0]      ctrl_word;
  logic [2:0]       ctrl_next;
  logic             ctrl_wr;

  logic             idx_wr, tbl_wr, step;
  logic [IDX_W-1:0] idx;
  logic [31:0]      idx_word, cur_word;

  logic             en_wr, bit0_wr, set_hit, clr_hit;
  logic             status, enable;
  logic [31:0]      info1, info2;

  logic [31:0]      rd_word;

  assign word_off = req_addr[11:2];
  assign lane     = req_addr[1:0];
  assign word_acc = (req_size == 2'd2);

  scr_bus_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .word_off   (word_off),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .sel        (sel)
  );

  // ---------------- control word ----------------
  assign ctrl_word = {ctl_lockdown, 22'd0, ctl_autoinc, 3'd0, ctl_err_resp, 4'd0};
  assign ctrl_wr   = wr_go & sel.ctrl & ~ctl_lockdown;
  assign ctrl_next = ctrl_bits(merge_word(ctrl_word, req_wdata, req_size, lane));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lockdown <= 1'b0;
      ctl_autoinc  <= 1'b1;
      ctl_err_resp <= 1'b0;
    end else if (ctrl_wr) begin
      {ctl_lockdown, ctl_autoinc, ctl_err_resp} <= ctrl_next;
    end
  end

  // ---------------- table and index ----------------
  assign idx_word = {{(32 - IDX_W){1'b0}}, idx};
  assign idx_wr   = wr_go & sel.index;
  assign tbl_wr   = wr_go & sel.table_d & ~ctl_lockdown;
  assign step     = sel.table_d & word_acc & ctl_autoinc & (rd_go | tbl_wr);

  scr_table #(
    .TBL_WORDS (TBL_WORDS),
    .IDX_W     (IDX_W)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .idx_wdata (merge_word(idx_word, req_wdata, req_size, lane)),
    .tbl_wr    (tbl_wr),
    .tbl_wdata (merge_word(cur_word, req_wdata, req_size, lane)),
    .step      (step),
    .idx       (idx),
    .cur_word  (cur_word),
    .lut_flat  (lut_words)
  );

  // ---------------- interrupt ----------------
  // zero-extended sub-word write: bit 0 is only written from lane 0
  assign bit0_wr = (lane == 2'd0) & req_wdata[0];
  assign en_wr   = wr_go & sel.en & ~ctl_lockdown;
  assign set_hit = wr_go & sel.set & bit0_wr;
  assign clr_hit = wr_go & sel.clr & bit0_wr;

  scr_irq_ctrl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_wr        (en_wr),
    .en_bit       (bit0_wr),
    .set_hit      (set_hit),
    .clr_hit      (clr_hit),
    .fault_strobe (fault_strobe),
    .fault_addr   (fault_addr),
    .fault_master (fault_master),
    .fault_nonsec (fault_nonsec),
    .fault_cfg_ns (fault_cfg_ns),
    .status       (status),
    .enable       (enable),
    .info1        (info1),
    .info2        (info2),
    .irq          (irq)
  );

  // ---------------- read path ----------------
  always_comb begin
    rd_word = '0;
    unique case (1'b1)
      sel.ctrl:    rd_word = ctrl_word;
      sel.maxidx:  rd_word = MAXIDX_VAL;
      sel.blkcfg:  rd_word = BLKCFG_VAL;
      sel.index:   rd_word = idx_word;
      sel.table_d: rd_word = cur_word;
      sel.stat:    rd_word = {31'd0, status};
      sel.en:      rd_word = {31'd0, enable};
      sel.info1:   rd_word = info1;
      sel.info2:   rd_word = info2;
      sel.ident:   rd_word = {24'd0, id_byte(word_off)};
      default:     rd_word = '0;
    endcase
  end

  assign rdata = rd_go ? extract_lanes(rd_word, req_size, lane) : 32'd0;

  // ---------------- assertions ----------------
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lockdown |=> ctl_lockdown);

  a_r4_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lockdown && req_valid && req_write && !sel.index)
      |=> ($stable(ctrl_word) && $stable(lut_words) && $stable(enable)));

  a_r3_ns_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_secure && word_off < W_IDBASE)
      |=> ($stable(ctrl_word) && $stable(idx) && $stable(lut_words) && $stable(enable)));

  a_r8_subword_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0) |-> (rdata[31:8] == 24'd0));

endmodule

// File: tb/sim_sec_cfg_regbank.sv
module sim_sec_cfg_regbank;

  localparam int NUM_BLOCKS = 200;
  localparam int TW         = (NUM_BLOCKS + 31) / 32;   // 7 table words

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic fault_strobe = 0, fault_nonsec = 0, fault_cfg_ns = 0;
  logic [31:0] fault_addr = '0;
  logic [15:0] fault_master = '0;
  logic irq, ctl_err_resp, ctl_autoinc, ctl_lockdown;
  logic [TW*32-1:0] lut_words;

  int vectors = 0;
  int miscompares = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  sec_cfg_regbank #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_LOG2(12)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rdata(rdata), .fault_strobe(fault_strobe),
    .fault_addr(fault_addr), .fault_master(fault_master),
    .fault_nonsec(fault_nonsec), .fault_cfg_ns(fault_cfg_ns), .irq(irq),
    .ctl_err_resp(ctl_err_resp), .ctl_autoinc(ctl_autoinc),
    .ctl_lockdown(ctl_lockdown), .lut_words(lut_words)
  );

  // monitor: pops one expected item per read cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && req_valid && !req_write) begin
        sb_item_t it;
        vectors++;
        if (sb_q.size() == 0) begin
          miscompares++;
          $display("FAIL scoreboard empty: read at %h got %h", req_addr, rdata);
        end else begin
          it = sb_q.pop_front();
          if (rdata !== it.exp) begin
            miscompares++;
            $display("FAIL %s: addr %h got %h expected %h", it.tag, req_addr, rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input bit sec,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    req_size = sz; req_secure = sec;
    if (!wr) sb_q.push_back('{exp, tag});
    @(posedge clk);
    #1;
    req_valid = 0; req_write = 0; fault_strobe = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [1:0] sz = 2, input bit sec = 1);
    access(1, a, d, sz, sec, 32'd0, "");
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                    input logic [1:0] sz = 2, input bit sec = 1);
    access(0, a, 32'd0, sz, sec, exp, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk);
    #1;
    fault_strobe = 0;
  endtask

  task automatic arm_fault(input logic [31:0] a, input logic [15:0] m,
                           input bit ns, input bit cfg);
    fault_addr = a; fault_master = m; fault_nonsec = ns; fault_cfg_ns = cfg;
    fault_strobe = 1;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] tword(int k);
    return 32'hA500_0000 + 32'(k) * 32'h111;
  endfunction

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] idv [12];
    logic [31:0] w3;
    idv = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8, 8'h1B, 8'h00,
            8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(12'h000, 32'h0000_0100, "R1 ctrl");
    rd(12'h018, 32'd0, "R1 index");
    rd(12'h028, 32'd1, "R1 enable");
    rd(12'h020, 32'd0, "R1 status");
    rd(12'h02C, 32'd0, "R1 info1");
    rd(12'h030, 32'd0, "R1 info2");
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({31'd0, |lut_words}, 32'd0, "R1 table zero");

    // R5 geometry
    rd(12'h010, 32'(TW - 1), "R5 max index");
    rd(12'h014, 32'd7, "R5 block config");

    // R2 control
    wr(12'h000, 32'h7FFF_FFFF);
    rd(12'h000, 32'h0000_0110, "R2 ctrl implemented bits");
    chk({29'd0, ctl_lockdown, ctl_autoinc, ctl_err_resp}, 32'd3, "R2 ctrl exports");

    // R6 fill with auto-increment, wrap
    wr(12'h018, 32'd0);
    for (int k = 0; k < TW; k++) wr(12'h01C, tword(k));
    rd(12'h018, 32'd0, "R6 index wrapped after fill");
    chk(lut_words[3*32 +: 32], tword(3), "R12 table word 3 export");
    chk(lut_words[(TW-1)*32 +: 32], tword(TW - 1), "R12 last table word export");
    for (int k = 0; k < TW; k++) rd(12'h01C, tword(k), "R6 streamed read");
    rd(12'h018, 32'd0, "R6 index wrapped after reads");

    // R5 modulo index
    wr(12'h018, 32'd10);
    rd(12'h018, 32'd3, "R5 index modulo");

    // R8 sub-word reads, R6 no advance
    rd(12'h01D, (tword(3) >> 8) & 32'hFF, "R8 byte lane 1", 2'd0);
    rd(12'h01E, (tword(3) >> 16) & 32'hFFFF, "R8 half lane 2", 2'd1);
    rd(12'h018, 32'd3, "R6 sub-word read no advance");

    // R7 sub-word table merge
    wr(12'h01F, 32'h5C, 2'd0);
    w3 = (tword(3) & 32'h00FF_FFFF) | 32'h5C00_0000;
    rd(12'h018, 32'd3, "R6 sub-word write no advance");
    rd(12'h01C, w3, "R7 table byte merge");
    chk(lut_words[3*32 +: 32], w3, "R12 merged word export");

    // R7 zero-extension on enable
    wr(12'h029, 32'h01, 2'd0);
    rd(12'h028, 32'd0, "R7 enable zero-extended");

    // R7 control merge: clear lane 1 keeps bit 4
    wr(12'h001, 32'h00, 2'd0);
    rd(12'h000, 32'h0000_0010, "R7 ctrl byte merge");
    rd(12'h01C, tword(4), "R6 read at index 4");
    rd(12'h018, 32'd4, "R6 no advance without autoinc");

    // R9 interrupt set/clear/enable
    wr(12'h028, 32'd1);
    wr(12'h034, 32'd1);
    chk({31'd0, irq}, 32'd1, "R9 irq after set");
    rd(12'h020, 32'd1, "R9 status set");
    wr(12'h028, 32'd0);
    chk({31'd0, irq}, 32'd0, "R9 irq masked");
    wr(12'h028, 32'd1);
    wr(12'h024, 32'd2);
    rd(12'h020, 32'd1, "R9 clear with bit0=0 ignored");
    wr(12'h024, 32'd1);
    rd(12'h020, 32'd0, "R9 status cleared");
    chk({31'd0, irq}, 32'd0, "R9 irq after clear");

    // R10 fault capture
    arm_fault(32'h0001_2340, 16'hBEEF, 1'b1, 1'b0);
    idle();
    chk({31'd0, irq}, 32'd1, "R10 irq on fault");
    rd(12'h020, 32'd1, "R10 status on fault");
    rd(12'h02C, 32'h0001_2340, "R10 info1");
    rd(12'h030, 32'h0001_BEEF, "R10 info2");
    arm_fault(32'h0000_0999, 16'h0001, 1'b0, 1'b1);
    idle();
    rd(12'h02C, 32'h0001_2340, "R10 second fault not captured");
    arm_fault(32'h0000_0777, 16'h0002, 1'b0, 1'b0);
    wr(12'h024, 32'd1);
    rd(12'h020, 32'd1, "R10 strobe beats clear");
    rd(12'h02C, 32'h0001_2340, "R10 info kept on overlap");
    wr(12'h024, 32'd1);
    rd(12'h020, 32'd0, "R10 cleared");
    arm_fault(32'h0000_0FF8, 16'h0012, 1'b0, 1'b1);
    idle();
    rd(12'h02C, 32'h0000_0FF8, "R10 recapture info1");
    rd(12'h030, 32'h0002_0012, "R10 recapture info2");
    wr(12'h024, 32'd1);

    // R3 non-secure
    rd(12'h000, 32'd0, "R3 ns read ctrl", 2'd2, 1'b0);
    wr(12'h018, 32'd2, 2'd2, 1'b0);
    wr(12'h034, 32'd1, 2'd2, 1'b0);
    rd(12'h018, 32'd4, "R3 ns index write ignored");
    rd(12'h020, 32'd0, "R3 ns set ignored");
    rd(12'h FE0, 32'h60, "R3 ns id read", 2'd2, 1'b0);

    // R11 ID bytes and read-zero offsets
    for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(4 * k), {24'd0, idv[k]}, "R11 id byte");
    wr(12'hFD0, 32'hFFFF_FFFF);
    rd(12'hFD0, 32'h04, "R11 id write ignored");
    rd(12'h024, 32'd0, "R11 clear reads zero");
    rd(12'h034, 32'd0, "R11 set reads zero");
    rd(12'h040, 32'd0, "R11 undefined reads zero");

    // R4 lockdown
    wr(12'h000, 32'h8000_0010);
    rd(12'h000, 32'h8000_0010, "R4 lock set");
    chk({31'd0, ctl_lockdown}, 32'd1, "R4 lock export");
    wr(12'h000, 32'd0);
    rd(12'h000, 32'h8000_0010, "R4 ctrl frozen");
    wr(12'h028, 32'd0);
    rd(12'h028, 32'd1, "R4 enable frozen");
    wr(12'h018, 32'd2);
    rd(12'h018, 32'd2, "R4 index still writable");
    wr(12'h01C, 32'h0000_DEAD);
    rd(12'h01C, tword(2), "R4 table frozen");

    // R4 only reset clears lockdown
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(12'h000, 32'h0000_0100, "R4 reset clears lock");
    chk({31'd0, |lut_words}, 32'd0, "R1 table cleared by reset");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: %0d reads not observed, expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule